// File: doc/BRIEF.md
# Periodic Self-Test Sequencer for a Ground Fault Interrupter

This block schedules and judges the recurring self-test of a ground fault interrupter. Each test cycle has two stages, always in the same order. In the first stage, at the start of a positive mains half cycle, the block drives a test-fault request and waits for the detection path to report the injected fault. In the second stage, a fixed delay into the following negative half cycle, it requests the thyristor gate and waits for a comparator that reports the thyristor test node falling below its threshold.

A cycle passes only when both stages pass. After a pass, the next cycle waits a long interval. After a failure, it retries after a short interval. A counter tracks consecutive failed cycles and a pass clears it. When the counter reaches a fixed limit, the block holds the gate request through a set number of positive half cycles to force a trip. It then latches the end-of-life indicator, which only reset clears. All intervals are given in clock cycles as parameters, so a simulation can use short times.

Top module: `stest_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `fault_test`, `gate_en` and `eol` are low. The first test waits for a low-to-high change of `phase_pos` that is seen after reset.
- R2: `fault_test` goes high one clock after the first clock that samples `phase_pos` high following a low sample. It goes low one clock after a clock that samples `fault_seen` high.
- R3: If `fault_seen` is never sampled high, `fault_test` stays high until one clock after the first low sample of `phase_pos`, and the cycle counts as failed.
- R4: `gate_en` goes high GATE_DELAY clocks after the clock that first samples `phase_pos` low in the test. This holds whether the first stage ended by detection or by timeout.
- R5: While `gate_en` is high in a test, a clock that samples `node_low` high removes `gate_en` one clock later. If `phase_pos` is sampled high first, with no `node_low`, the gate stage fails. If the positive half returns before the delay ends, the gate stage also fails.
- R6: After a passing cycle, a timer waits PASS_WAIT clocks and then the block arms for the next positive-half start.
- R7: After a failing cycle, a timer waits FAIL_WAIT clocks and then the block arms for the next positive-half start.
- R8: On the FAIL_LIMIT-th consecutive failed cycle, `gate_en` is held high through each of the next TRIP_HALFS positive half cycles. Each of these spans from one clock after a rising phase is seen to one clock after a falling phase is seen. `eol` is then set.
- R9: A passing cycle clears the count of consecutive failures.
- R10: Once set, `eol` stays high whatever the inputs do, until `rst`.
- R11: `fault_test` and `gate_en` are never high together, and both are low while `eol` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_pos | input | 1 | High during the positive mains half cycle |
| fault_seen | input | 1 | Detection path reports the injected test fault |
| node_low | input | 1 | Thyristor test node is below its threshold |
| fault_test | output | 1 | Request to inject the test fault |
| gate_en | output | 1 | Thyristor gate enable request |
| eol | output | 1 | End-of-life indicator, latched |

## Verification
Every output is a decode of the state register. Each result is therefore due exactly one clock after the edge that samples the input causing it: detection drops `fault_test` one clock later, the gate rises GATE_DELAY clocks after the negative half is first sampled, and a passing comparator drops `gate_en` one clock later. The bench drives inputs on the falling edge. Its reference model advances on the rising edge from those same sampled inputs. The outputs are compared on the next falling edge, so each expected change is checked in the cycle it is due. Spacing between test starts is measured from one rise of `fault_test` to the next. The end-of-life escalation is checked by counting gate pulses.

// File: rtl/stest_pkg.sv
package stest_pkg;

    typedef enum logic [3:0] {
        ST_ARM,
        ST_INJECT,
        ST_HOLD,
        ST_DELAY,
        ST_GATE,
        ST_DECIDE,
        ST_WAIT,
        ST_TRIP_ARM,
        ST_TRIP_ON,
        ST_EOL
    } stest_state_e;

    typedef struct packed {
        logic inj_ok;
        logic gate_ok;
        logic long_wait;
    } stest_result_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned top);
        return (top < 2) ? 1 : $clog2(top + 1);
    endfunction

endpackage

// File: rtl/stest_phase_edge.sv
module stest_phase_edge (
    input  logic clk,
    input  logic rst,
    input  logic phase_pos,
    output logic pos_start
);
    logic phase_q;

    // Reset value 1 keeps a half cycle already under way from counting as a start.
    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b1;
        else     phase_q <= phase_pos;
    end

    assign pos_start = phase_pos & ~phase_q;
endmodule

// File: rtl/stest_timer.sv
module stest_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else if (inc)   count <= count + 1'b1;
    end
endmodule

// File: rtl/stest_fail_ctr.sv
module stest_fail_ctr #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int unsigned FW = stest_pkg::cnt_bits(LIMIT);

    logic [FW-1:0] fails;

    always_ff @(posedge clk) begin
        if (rst || clr)              fails <= '0;
        else if (inc && !(&fails))   fails <= fails + 1'b1;
    end

    // True when one more failure reaches the limit.
    assign at_last = (fails == FW'(LIMIT - 1));
endmodule

// File: rtl/stest_seq.sv
module stest_seq
    import stest_pkg::*;
#(
    parameter int unsigned PASS_WAIT  = 1_440_000_000,
    parameter int unsigned FAIL_WAIT  = 2_200_000,
    parameter int unsigned GATE_DELAY = 6_000,
    parameter int unsigned FAIL_LIMIT = 16,
    parameter int unsigned TRIP_HALFS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic phase_pos,
    input  logic fault_seen,
    input  logic node_low,
    output logic fault_test,
    output logic gate_en,
    output logic eol
);
    localparam int unsigned TOP   = umax(umax(PASS_WAIT, FAIL_WAIT), umax(GATE_DELAY, TRIP_HALFS));
    localparam int unsigned TMR_W = cnt_bits(TOP);

    stest_state_e  state, nxt;
    stest_result_t res, res_nxt;
    logic          pos_start;
    logic          tmr_clr, tmr_inc;
    logic [TMR_W-1:0] tmr;
    logic          fc_clr, fc_inc, fc_last;
    logic [TMR_W-1:0] wait_last;

    stest_phase_edge u_edge (
        .clk(clk), .rst(rst), .phase_pos(phase_pos), .pos_start(pos_start)
    );

    stest_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .clr(tmr_clr), .inc(tmr_inc), .count(tmr)
    );

    stest_fail_ctr #(.LIMIT(FAIL_LIMIT)) u_fails (
        .clk(clk), .rst(rst), .clr(fc_clr), .inc(fc_inc), .at_last(fc_last)
    );

    assign wait_last = res.long_wait ? TMR_W'(PASS_WAIT - 1) : TMR_W'(FAIL_WAIT - 1);

    always_comb begin
        nxt     = state;
        res_nxt = res;
        tmr_clr = 1'b0;
        tmr_inc = 1'b0;
        fc_clr  = 1'b0;
        fc_inc  = 1'b0;
        unique case (state)
            ST_ARM: if (pos_start) nxt = ST_INJECT;
            ST_INJECT: begin
                if (fault_seen) begin
                    res_nxt.inj_ok = 1'b1;
                    nxt            = ST_HOLD;
                end else if (!phase_pos) begin
                    res_nxt.inj_ok = 1'b0;
                    nxt            = ST_DELAY;
                    tmr_clr        = 1'b1;
                end
            end
            ST_HOLD: if (!phase_pos) begin
                nxt     = ST_DELAY;
                tmr_clr = 1'b1;
            end
            ST_DELAY: begin
                if (phase_pos) begin
                    res_nxt.gate_ok = 1'b0;
                    nxt             = ST_DECIDE;
                end else if (tmr == TMR_W'(GATE_DELAY - 1)) begin
                    nxt = ST_GATE;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            ST_GATE: begin
                if (node_low) begin
                    res_nxt.gate_ok = 1'b1;
                    nxt             = ST_DECIDE;
                end else if (phase_pos) begin
                    res_nxt.gate_ok = 1'b0;
                    nxt             = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                tmr_clr = 1'b1;
                if (res.inj_ok && res.gate_ok) begin
                    fc_clr            = 1'b1;
                    res_nxt.long_wait = 1'b1;
                    nxt               = ST_WAIT;
                end else begin
                    fc_inc            = 1'b1;
                    res_nxt.long_wait = 1'b0;
                    nxt               = fc_last ? ST_TRIP_ARM : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (tmr == wait_last) nxt = ST_ARM;
                else                  tmr_inc = 1'b1;
            end
            ST_TRIP_ARM: if (pos_start) nxt = ST_TRIP_ON;
            ST_TRIP_ON: if (!phase_pos) begin
                if (tmr == TMR_W'(TRIP_HALFS - 1)) begin
                    nxt = ST_EOL;
                end else begin
                    tmr_inc = 1'b1;
                    nxt     = ST_TRIP_ARM;
                end
            end
            ST_EOL: nxt = ST_EOL;
            default: nxt = ST_ARM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_ARM;
            res   <= '0;
        end else begin
            state <= nxt;
            res   <= res_nxt;
        end
    end

    assign fault_test = (state == ST_INJECT);
    assign gate_en    = (state == ST_GATE) || (state == ST_TRIP_ON);
    assign eol        = (state == ST_EOL);
endmodule

// File: rtl/stest_seq_chk.sv
module stest_seq_chk (
    input logic clk,
    input logic rst,
    input logic phase_pos,
    input logic fault_seen,
    input logic node_low,
    input logic fault_test,
    input logic gate_en,
    input logic eol
);
    // R2: a start needs a high sample right after a low one
    a_r2_start_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_test) |-> ($past(phase_pos) && !$past(phase_pos, 2)));

    // R2: detection ends the injection
    a_r2_drop_on_detect: assert property (@(posedge clk) disable iff (rst)
        (fault_test && fault_seen) |=> !fault_test);

    // R3: injection never outlives the positive half
    a_r3_drop_on_neg: assert property (@(posedge clk) disable iff (rst)
        (fault_test && !phase_pos) |=> !fault_test);

    // R5: comparator in the negative half removes the gate
    a_r5_gate_release: assert property (@(posedge clk) disable iff (rst)
        (gate_en && !phase_pos && node_low) |=> !gate_en);

    // R10: end-of-life is sticky
    a_r10_eol_sticky: assert property (@(posedge clk) disable iff (rst)
        eol |=> eol);

    // R11: outputs exclusive
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fault_test && gate_en) && !(eol && (fault_test || gate_en)));
endmodule

bind stest_seq stest_seq_chk u_chk (
    .clk(clk), .rst(rst), .phase_pos(phase_pos), .fault_seen(fault_seen),
    .node_low(node_low), .fault_test(fault_test), .gate_en(gate_en), .eol(eol)
);

// File: tb/stest_seq_bench.sv
module stest_seq_bench;
    localparam int PW   = 300;
    localparam int FW   = 60;
    localparam int GD   = 6;
    localparam int FL   = 16;
    localparam int TH   = 4;
    localparam int HALF = 20;
    localparam int WDOG = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phase_pos = 1'b0;
    logic fault_seen = 1'b0;
    logic node_low = 1'b0;
    logic fault_test, gate_en, eol;

    always #4 clk = ~clk;

    stest_seq #(
        .PASS_WAIT(PW), .FAIL_WAIT(FW), .GATE_DELAY(GD),
        .FAIL_LIMIT(FL), .TRIP_HALFS(TH)
    ) u_stest_seq (
        .clk(clk), .rst(rst), .phase_pos(phase_pos), .fault_seen(fault_seen),
        .node_low(node_low), .fault_test(fault_test), .gate_en(gate_en), .eol(eol)
    );

    int checks = 0;
    int fails  = 0;
    bit en_f = 1'b1;
    bit en_n = 1'b1;
    bit count_trip = 1'b0;
    int trip_rises = 0;

    // behavioural reference
    int m_mode = 0, m_cnt = 0, m_wait = 0, m_fails = 0, m_done = 0;
    bit m_pq = 1'b1, m_inj = 1'b0, m_gate = 1'b0, m_last_pass = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_cnt = 0; m_fails = 0; m_pq = 1'b1;
            m_inj = 1'b0; m_gate = 1'b0;
        end else begin
            case (m_mode)
                0: if (phase_pos && !m_pq) m_mode = 1;
                1: if (fault_seen) begin m_inj = 1'b1; m_mode = 2; end
                   else if (!phase_pos) begin m_inj = 1'b0; m_mode = 3; m_cnt = 0; end
                2: if (!phase_pos) begin m_mode = 3; m_cnt = 0; end
                3: if (phase_pos) begin m_gate = 1'b0; m_mode = 5; end
                   else if (m_cnt == GD - 1) m_mode = 4;
                   else m_cnt++;
                4: if (node_low) begin m_gate = 1'b1; m_mode = 5; end
                   else if (phase_pos) begin m_gate = 1'b0; m_mode = 5; end
                5: begin
                    m_done++;
                    m_cnt = 0;
                    m_last_pass = m_inj && m_gate;
                    if (m_last_pass) begin m_fails = 0; m_wait = PW; m_mode = 6; end
                    else begin
                        m_fails++;
                        if (m_fails == FL) m_mode = 7;
                        else begin m_wait = FW; m_mode = 6; end
                    end
                end
                6: if (m_cnt == m_wait - 1) m_mode = 0; else m_cnt++;
                7: if (phase_pos && !m_pq) m_mode = 8;
                8: if (!phase_pos) begin
                       if (m_cnt == TH - 1) m_mode = 9;
                       else begin m_cnt++; m_mode = 7; end
                   end
                default: m_mode = 9;
            endcase
            m_pq = phase_pos;
        end
    end

    int  cyc = 0, ph_cnt = 0, last_rise = -1;
    bit  ft_prev = 1'b0, ge_prev = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WDOG);
            finish_run();
        end
        // per-cycle comparison against the reference
        check("R2/R3 fault_test", int'(fault_test), int'(m_mode == 1));
        check("R4/R5/R8 gate_en", int'(gate_en), int'(m_mode == 4 || m_mode == 8));
        check("R8/R10 eol", int'(eol), int'(m_mode == 9));
        // start spacing
        if (!rst && fault_test && !ft_prev) begin
            if (last_rise >= 0) begin
                if (m_last_pass) check("R6 pass spacing", int'(cyc - last_rise >= PW), 1);
                else check("R7 retry spacing",
                           int'(cyc - last_rise >= FW && cyc - last_rise <= FW + 4 * HALF + GD + 10), 1);
            end
            last_rise = cyc;
        end
        if (count_trip && gate_en && !ge_prev) trip_rises++;
        ft_prev = fault_test;
        ge_prev = gate_en;
        // mains phase and responders
        ph_cnt++;
        if (ph_cnt == HALF) begin ph_cnt = 0; phase_pos = ~phase_pos; end
        fault_seen = en_f && fault_test;
        node_low   = en_n && gate_en;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", int'({fault_test, gate_en, eol}), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", int'({fault_test, gate_en, eol}), 0);
        wait (m_done == 1); en_f = 1'b0;            // next: injection failure
        wait (m_done == 2); en_f = 1'b1; en_n = 1'b0; // next: gate failure
        wait (m_done == 3); en_n = 1'b1;             // next: pass clears count
        wait (m_done == 4); en_f = 1'b0;             // 15 failures follow
        wait (m_done == 19);
        @(negedge clk);
        check("R9 no trip after cleared count", int'(eol || m_mode >= 7), 0);
        en_f = 1'b1;
        wait (m_done == 20); en_f = 1'b0;
        wait (m_done == 36); count_trip = 1'b1;
        wait (eol == 1'b1);
        @(negedge clk);
        check("R8 trip gate pulses", trip_rises, TH);
        check("R8 eol after trip", int'(eol), 1);
        en_f = 1'b1; en_n = 1'b1;
        repeat (500) @(negedge clk);
        check("R10 eol held", int'(eol), 1);
        check("R11 outputs quiet at eol", int'({fault_test, gate_en}), 0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 reset clears eol", int'(eol), 0);
        finish_run();
    end
endmodule